// File: doc/BRIEF.md
# Signed Up/Down Event Counter

This block counts events arriving on two level inputs: every rising transition of the up input raises a signed two's-complement accumulator by one, and every rising transition of the down input lowers it by one. An input that stays high counts once. The accumulator is compared each cycle with a signed preset to drive a registered done flag.

When the count runs past either end of the signed range, it wraps to the opposite end. A matching overflow or underflow flag is then raised and stays set. A synchronous clear input zeroes the accumulator and drops all three flags. A fixed 16-bit status word gathers the sampled input levels and the flags, for a neighbour that decodes it by bit position.

Top module: `updn_event_counter`

## Requirements
- R1: A rising transition of `up_i` (low on the previous clock edge, high on this one) increments `acc_o` by one at that edge. An input held high counts only once.
- R2: A rising transition of `dn_i` decrements `acc_o` by one at that edge.
- R3: When both inputs rise on the same clock edge, `acc_o` and both wrap flags stay unchanged.
- R4: An increment from the largest positive value (2^(W-1)-1) wraps `acc_o` to the most negative value (-2^(W-1)) and sets `ovf_o`.
- R5: A decrement from -2^(W-1) wraps `acc_o` to 2^(W-1)-1 and sets `unf_o`.
- R6: `ovf_o` and `unf_o` stay high once set, until a clear.
- R7: `done_o` is registered. After each non-clear edge it equals the signed comparison of the new accumulator value being greater than or equal to the signed `preset_i` sampled at that edge.
- R8: An edge with `clr_i` high sets `acc_o` to zero and forces `done_o`, `ovf_o` and `unf_o` low. Input transitions sampled at that edge are not counted.
- R9: `ctrl_o` bit 15 holds the `up_i` level and bit 14 the `dn_i` level, both sampled at the last edge. Bit 13 is done, bit 12 overflow and bit 11 underflow. Bits 10 to 0 are zero.
- R10: While `rst_n` is low, `acc_o`, all flags and `ctrl_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Count-up condition level |
| dn_i | input | 1 | Count-down condition level |
| clr_i | input | 1 | Synchronous clear of count and flags |
| preset_i | input | W | Signed preset for the done comparison |
| acc_o | output | W | Signed accumulator |
| done_o | output | 1 | Accumulator is at or above the preset |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| ctrl_o | output | 16 | Packed status word |

## Verification
The bench builds the counter with W = 8, so both wrap points (+127 and -128) lie a few hundred cycles from zero. This lets directed runs cross each boundary, and lets the random phase cross them again, within the cycle budget. At this width, negative presets and presets near the limits exercise the signed done comparison at both extremes. The arithmetic is written purely in terms of W, so the default 16-bit build differs only in where the wrap points fall.

// File: rtl/updn_pkg.sv
package updn_pkg;
    localparam int CTRL_W   = 16;
    localparam int BIT_UP   = 15;
    localparam int BIT_DN   = 14;
    localparam int BIT_DONE = 13;
    localparam int BIT_OVF  = 12;
    localparam int BIT_UNF  = 11;

    typedef struct packed {
        logic done;
        logic ovf;
        logic unf;
    } flags_t;
endpackage

// File: rtl/updn_edge.sv
module updn_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] lvl_q_o,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic lvl_d, lvl_q;

        always_comb begin
            lvl_d = lvl_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= lvl_d;
        end

        assign lvl_q_o[g] = lvl_q;
        assign rise_o[g]  = lvl_i[g] & ~lvl_q;

        assert_rise_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> lvl_q_o[g]);
    end
endmodule

// File: rtl/updn_step.sv
module updn_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_i,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] acc_o,
    output logic         wrap_hi_o,
    output logic         wrap_lo_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        acc_o     = acc_i;
        wrap_hi_o = 1'b0;
        wrap_lo_o = 1'b0;
        if (inc_i && !dec_i) begin
            if (acc_i == MAXV) begin
                acc_o     = MINV;
                wrap_hi_o = 1'b1;
            end else begin
                acc_o = acc_i + 1'b1;
            end
        end else if (dec_i && !inc_i) begin
            if (acc_i == MINV) begin
                acc_o     = MAXV;
                wrap_lo_o = 1'b1;
            end else begin
                acc_o = acc_i - 1'b1;
            end
        end
    end

    always_comb begin
        assert_single_wrap_R3: assert (!(wrap_hi_o && wrap_lo_o));
    end
endmodule

// File: rtl/updn_status.sv
module updn_status
    import updn_pkg::*;
(
    input  logic              up_lvl_i,
    input  logic              dn_lvl_i,
    input  flags_t            flg_i,
    output logic [CTRL_W-1:0] ctrl_o
);
    always_comb begin
        ctrl_o           = '0;
        ctrl_o[BIT_UP]   = up_lvl_i;
        ctrl_o[BIT_DN]   = dn_lvl_i;
        ctrl_o[BIT_DONE] = flg_i.done;
        ctrl_o[BIT_OVF]  = flg_i.ovf;
        ctrl_o[BIT_UNF]  = flg_i.unf;
    end
endmodule

// File: rtl/updn_event_counter.sv
module updn_event_counter
    import updn_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic              clr_i,
    input  logic [W-1:0]      preset_i,
    output logic [W-1:0]      acc_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic              unf_o,
    output logic [CTRL_W-1:0] ctrl_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] acc;
        flags_t       flg;
    } state_t;

    state_t       st_d, st_q;
    logic [1:0]   lvl_q, rise;
    logic [W-1:0] acc_step;
    logic         wrap_hi, wrap_lo;

    updn_edge #(.N(2)) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   ({dn_i, up_i}),
        .lvl_q_o (lvl_q),
        .rise_o  (rise)
    );

    updn_step #(.W(W)) step_i (
        .acc_i     (st_q.acc),
        .inc_i     (rise[0]),
        .dec_i     (rise[1]),
        .acc_o     (acc_step),
        .wrap_hi_o (wrap_hi),
        .wrap_lo_o (wrap_lo)
    );

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.acc = '0;
            st_d.flg = '0;
        end else begin
            st_d.acc      = acc_step;
            st_d.flg.ovf  = st_q.flg.ovf | wrap_hi;
            st_d.flg.unf  = st_q.flg.unf | wrap_lo;
            st_d.flg.done = $signed(acc_step) >= $signed(preset_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    updn_status status_i (
        .up_lvl_i (lvl_q[0]),
        .dn_lvl_i (lvl_q[1]),
        .flg_i    (st_q.flg),
        .ctrl_o   (ctrl_o)
    );

    assign acc_o  = st_q.acc;
    assign done_o = st_q.flg.done;
    assign ovf_o  = st_q.flg.ovf;
    assign unf_o  = st_q.flg.unf;

    assert_both_edges_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && !ctrl_o[BIT_UP] && dn_i && !ctrl_o[BIT_DN] && !clr_i)
        |=> $stable(acc_o) && $stable(ovf_o) && $stable(unf_o));

    assert_ovf_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && !ctrl_o[BIT_UP] && !(dn_i && !ctrl_o[BIT_DN]) && !clr_i && acc_o == MAXV)
        |=> (acc_o == MINV) && ovf_o);

    assert_unf_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_i && !ctrl_o[BIT_DN] && !(up_i && !ctrl_o[BIT_UP]) && !clr_i && acc_o == MINV)
        |=> (acc_o == MAXV) && unf_o);

    assert_sticky_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_o || unf_o) && !clr_i) |=> ($past(ovf_o) -> ovf_o) && ($past(unf_o) -> unf_o));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0) && !done_o && !ovf_o && !unf_o);

    assert_level_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ctrl_o[BIT_UP] == $past(up_i)) && (ctrl_o[BIT_DN] == $past(dn_i)));
endmodule

// File: tb/updn_event_counter_tb_top.sv
`timescale 1ns/1ps
module updn_event_counter_tb_top;
    localparam int W    = 8;
    localparam int MAXI = (1 << (W-1)) - 1;
    localparam int MINI = -(1 << (W-1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up_i = 1'b0, dn_i = 1'b0, clr_i = 1'b0;
    logic [W-1:0] preset_i = '0;
    logic [W-1:0] acc_o;
    logic         done_o, ovf_o, unf_o;
    logic [15:0]  ctrl_o;

    int n_chk = 0, n_bad = 0;
    int m_acc = 0;
    bit m_ovf = 0, m_unf = 0, m_done = 0, m_pu = 0, m_pd = 0;

    always #2.5 clk = ~clk;

    updn_event_counter #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i), .clr_i(clr_i),
        .preset_i(preset_i), .acc_o(acc_o), .done_o(done_o), .ovf_o(ovf_o),
        .unf_o(unf_o), .ctrl_o(ctrl_o)
    );

    function automatic logic [15:0] exp_ctrl();
        logic [15:0] e = '0;
        e[15] = m_pu; e[14] = m_pd; e[13] = m_done; e[12] = m_ovf; e[11] = m_unf;
        return e;
    endfunction

    task automatic check_all(input string req);
        n_chk++;
        if ($signed(acc_o) != m_acc || done_o != m_done || ovf_o != m_ovf ||
            unf_o != m_unf || ctrl_o != exp_ctrl()) begin
            n_bad++;
            $display("FAIL %s: acc=%0d done=%0b ovf=%0b unf=%0b ctrl=%h expected acc=%0d done=%0b ovf=%0b unf=%0b ctrl=%h",
                     req, $signed(acc_o), done_o, ovf_o, unf_o, ctrl_o,
                     m_acc, m_done, m_ovf, m_unf, exp_ctrl());
        end
    endtask

    task automatic step(input bit up, input bit dn, input bit clr, input string req);
        bit eu = up && !m_pu;
        bit ed = dn && !m_pd;
        up_i = up; dn_i = dn; clr_i = clr;
        if (clr) begin
            m_acc = 0; m_ovf = 0; m_unf = 0; m_done = 0;
        end else begin
            if (eu && !ed) begin
                if (m_acc == MAXI) begin m_acc = MINI; m_ovf = 1; end
                else m_acc = m_acc + 1;
            end else if (ed && !eu) begin
                if (m_acc == MINI) begin m_acc = MAXI; m_unf = 1; end
                else m_acc = m_acc - 1;
            end
            m_done = (m_acc >= int'($signed(preset_i)));
        end
        m_pu = up; m_pd = dn;
        @(posedge clk); #1;
        check_all(req);
    endtask

    task automatic pulse_up(input string req);
        step(1, 0, 0, req); step(0, 0, 0, req);
    endtask

    task automatic pulse_dn(input string req);
        step(0, 1, 0, req); step(0, 0, 0, req);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        preset_i = 8'sd5;
        repeat (3) @(posedge clk);
        #1 check_all("R10");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R10");

        // R1: single rises and a held level
        pulse_up("R1"); pulse_up("R1");
        step(1, 0, 0, "R1"); step(1, 0, 0, "R1"); step(1, 0, 0, "R1"); step(0, 0, 0, "R1");
        // R2
        pulse_dn("R2"); pulse_dn("R2"); pulse_dn("R2");
        // R3: simultaneous rises
        step(1, 1, 0, "R3"); step(0, 0, 0, "R3");
        // R7: done with a negative preset, then a positive one
        preset_i = -8'sd3;
        step(0, 0, 0, "R7");
        pulse_dn("R7"); pulse_dn("R7"); pulse_dn("R7"); pulse_dn("R7");
        preset_i = 8'sd0;
        step(0, 0, 0, "R7");
        // R9: status bits with both levels high
        step(1, 1, 0, "R9"); step(0, 1, 0, "R9"); step(0, 0, 0, "R9");
        // R4: run up to the positive limit and wrap
        preset_i = 8'sd127;
        while (m_acc != MAXI) pulse_up("R4");
        pulse_up("R4");
        // R6: overflow stays set while counting on
        pulse_up("R6"); pulse_dn("R6"); pulse_dn("R6");
        // R8: clear with a rise in the same cycle, held into release
        step(1, 0, 1, "R8"); step(1, 0, 0, "R8"); step(0, 0, 0, "R8");
        // R5: run down past the negative limit
        preset_i = -8'sd128;
        while (m_acc != MINI) pulse_dn("R5");
        pulse_dn("R5");
        pulse_dn("R6"); pulse_up("R6");
        step(0, 0, 1, "R8"); step(0, 0, 0, "R8");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            if (k % 97 == 0) preset_i = W'($urandom);
            step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 ($urandom_range(0, 199) == 0), "R1/R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule